// File: doc/BRIEF.md
# Multi-Level Interrupt Priority Controller

This block holds pending interrupt sources sorted into priority levels. Every level owns a 64-bit source vector, and a registered one-bit-per-level summary marks the levels that hold at least one pending source. Three commands change the state: post (level, source index), clear (level, source index) and clear-all. A combinational query port tells whether one chosen level holds anything, and a second output tells whether any level does.

An evaluation path merges a software request vector with the summary bits of the external levels. It produces a candidate priority ID and a summary mask, and compares the candidate against the current priority level supplied by the core. When the candidate is strictly higher, the block raises a request in the same cycle and presents the mask and ID for the core to latch. Commands that name a level or source outside the storage are dropped and flagged on a one-cycle error pulse.

Top module: `int_prio_ctrl`

## Requirements
- R1: After reset, every level query and the any-pending output read 0, the request output is 0 and the error output is 0.
- R2: A valid post sets the addressed source bit. From the next cycle the query for that level reads 1 and any-pending reads 1. Other levels are unaffected.
- R3: A clear resets the addressed source bit. The level's summary bit, and so its query, drops only once no source of that level remains set.
- R4: Clear-all empties every level and the summary in one cycle, and it overrides any post or clear given in the same cycle.
- R5: When a post and a clear address the same level and source in the same cycle, the clear wins and the bit ends at 0.
- R6: The level query is combinational from the registered state. A query level of 32 or more (6-bit input) reads 0 regardless of the stored state.
- R7: Software request bits 1 to 15 are scanned upward. Each set bit i sets bit i of the summary mask and makes the candidate ID equal to i minus 1 plus 1, so the highest set bit gives the ID. Bit 0 and bits 16 to 31 of the software input are ignored.
- R8: Summary bits of levels 16 to 31 are scanned after the software bits. Each pending level i sets mask bit i and makes the candidate ID i, so the highest pending external level overrides any software ID. Pending levels 0 to 15 never take part in the evaluation.
- R9: The request output is 1 only when the candidate ID is nonzero and strictly greater than the current priority level input. It is valid in the same cycle. While it is 0, the mask and ID outputs are 0.
- R10: A post or clear with level 32 or more (6-bit field) or source index 64 or more (7-bit field) changes no state. In the next cycle it gives exactly a one-cycle pulse on the error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| post_valid_i | input | 1 | Post command strobe |
| post_level_i | input | 6 | Level of the post command |
| post_index_i | input | 7 | Source index of the post command |
| clear_valid_i | input | 1 | Clear command strobe |
| clear_level_i | input | 6 | Level of the clear command |
| clear_index_i | input | 7 | Source index of the clear command |
| clear_all_i | input | 1 | Empty all levels |
| query_level_i | input | 6 | Level inspected by the query output |
| query_hit_o | output | 1 | Queried level holds a pending source |
| any_pending_o | output | 1 | Some level holds a pending source |
| sw_req_i | input | 32 | Software request vector |
| cur_ipl_i | input | 6 | Current priority level of the core |
| irq_o | output | 1 | Interrupt request |
| irq_summary_o | output | 32 | Summary mask to be latched on a request |
| irq_id_o | output | 6 | Priority ID to be latched on a request |
| cmd_err_o | output | 1 | One-cycle pulse after a command out of range |

## Verification
A vector table drives the evaluation with software-only patterns (one bit, two bits, bits outside the scanned window), external-only patterns (one level, the top level, a level below the external window) and mixed patterns. Together these separate the software offset from the external mapping, show which source overrides the other, and show how the mask is merged. Each pattern is paired with priority levels just below and equal to the candidate, which exposes an off-by-one in the strict comparison. Directed sequences then cover multi-source clears, post and clear colliding on one bit, clear-all against a simultaneous post, and out-of-range fields. Those fields are chosen to alias onto real levels and sources if the design truncated them.

// File: rtl/int_prio_pkg.sv
package int_prio_pkg;
  localparam int unsigned DEF_NUM_LEVELS = 32;
  localparam int unsigned DEF_SRC_W      = 64;
  localparam int unsigned DEF_SW_MIN     = 1;
  localparam int unsigned DEF_SW_MAX     = 16;
  localparam int unsigned DEF_EXT_MIN    = 16;
  localparam int unsigned DEF_EXT_MAX    = 32;
endpackage

// File: rtl/int_cmd_decode.sv
module int_cmd_decode #(
  parameter int unsigned NUM_LEVELS = int_prio_pkg::DEF_NUM_LEVELS,
  parameter int unsigned SRC_W      = int_prio_pkg::DEF_SRC_W,
  localparam int unsigned LVL_IN_W  = $clog2(NUM_LEVELS) + 1,
  localparam int unsigned IDX_IN_W  = $clog2(SRC_W) + 1
) (
  input  logic                  valid_i,
  input  logic [LVL_IN_W-1:0]   level_i,
  input  logic [IDX_IN_W-1:0]   index_i,
  output logic [NUM_LEVELS-1:0] lvl_sel_o,
  output logic [SRC_W-1:0]      bit_sel_o,
  output logic                  bad_o
);
  logic in_range;

  always_comb begin
    in_range = (32'(level_i) < NUM_LEVELS) && (32'(index_i) < SRC_W);
    bad_o    = valid_i && !in_range;
  end

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    assign lvl_sel_o[l] = valid_i && in_range && (32'(level_i) == l);
  end

  for (genvar b = 0; b < SRC_W; b++) begin : g_bit
    assign bit_sel_o[b] = (32'(index_i) == b);
  end
endmodule

// File: rtl/int_pend_store.sv
module int_pend_store #(
  parameter int unsigned NUM_LEVELS = int_prio_pkg::DEF_NUM_LEVELS,
  parameter int unsigned SRC_W      = int_prio_pkg::DEF_SRC_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clear_all_i,
  input  logic [NUM_LEVELS-1:0]            post_lvl_i,
  input  logic [SRC_W-1:0]                 post_bit_i,
  input  logic [NUM_LEVELS-1:0]            clr_lvl_i,
  input  logic [SRC_W-1:0]                 clr_bit_i,
  output logic [NUM_LEVELS-1:0][SRC_W-1:0] vec_o,
  output logic [NUM_LEVELS-1:0]            sum_o
);
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
    logic [SRC_W-1:0] vec_q, vec_d, set_m, clr_m;
    logic             sum_q, sum_d, touch;

    always_comb begin
      set_m = post_lvl_i[g] ? post_bit_i : '0;
      clr_m = clr_lvl_i[g]  ? clr_bit_i  : '0;
      touch = clear_all_i || post_lvl_i[g] || clr_lvl_i[g];
      if (clear_all_i) begin
        vec_d = '0;
      end else begin
        // clear is applied after set so a same-bit collision ends cleared
        vec_d = (vec_q | set_m) & ~clr_m;
      end
      sum_d = |vec_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vec_q <= '0;
        sum_q <= 1'b0;
      end else if (touch) begin
        vec_q <= vec_d;
        sum_q <= sum_d;
      end
    end

    assign vec_o[g] = vec_q;
    assign sum_o[g] = sum_q;
  end
endmodule

// File: rtl/int_prio_eval.sv
module int_prio_eval #(
  parameter int unsigned NUM_LEVELS = int_prio_pkg::DEF_NUM_LEVELS,
  parameter int unsigned SW_MIN     = int_prio_pkg::DEF_SW_MIN,
  parameter int unsigned SW_MAX     = int_prio_pkg::DEF_SW_MAX,
  parameter int unsigned EXT_MIN    = int_prio_pkg::DEF_EXT_MIN,
  parameter int unsigned EXT_MAX    = int_prio_pkg::DEF_EXT_MAX,
  localparam int unsigned ID_W      = $clog2(NUM_LEVELS) + 1
) (
  input  logic [NUM_LEVELS-1:0] sw_req_i,
  input  logic [NUM_LEVELS-1:0] sum_i,
  input  logic [ID_W-1:0]       cur_ipl_i,
  output logic                  irq_o,
  output logic [NUM_LEVELS-1:0] mask_o,
  output logic [ID_W-1:0]       id_o
);
  logic [ID_W-1:0]       cand;
  logic [NUM_LEVELS-1:0] mask;
  logic                  win;

  always_comb begin
    cand = '0;
    mask = '0;
    for (int i = SW_MIN; i < SW_MAX; i++) begin
      if (sw_req_i[i]) begin
        cand    = ID_W'(i - SW_MIN + 1);
        mask[i] = 1'b1;
      end
    end
    for (int i = EXT_MIN; i < EXT_MAX; i++) begin
      if (sum_i[i]) begin
        cand    = ID_W'(i);
        mask[i] = 1'b1;
      end
    end
    win    = (cand != '0) && (cand > cur_ipl_i);
    irq_o  = win;
    mask_o = win ? mask : '0;
    id_o   = win ? cand : '0;
  end
endmodule

// File: rtl/int_prio_ctrl.sv
module int_prio_ctrl #(
  parameter int unsigned NUM_LEVELS = int_prio_pkg::DEF_NUM_LEVELS,
  parameter int unsigned SRC_W      = int_prio_pkg::DEF_SRC_W,
  parameter int unsigned SW_MIN     = int_prio_pkg::DEF_SW_MIN,
  parameter int unsigned SW_MAX     = int_prio_pkg::DEF_SW_MAX,
  parameter int unsigned EXT_MIN    = int_prio_pkg::DEF_EXT_MIN,
  parameter int unsigned EXT_MAX    = int_prio_pkg::DEF_EXT_MAX,
  localparam int unsigned LVL_W     = $clog2(NUM_LEVELS),
  localparam int unsigned LVL_IN_W  = LVL_W + 1,
  localparam int unsigned IDX_IN_W  = $clog2(SRC_W) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  post_valid_i,
  input  logic [LVL_IN_W-1:0]   post_level_i,
  input  logic [IDX_IN_W-1:0]   post_index_i,
  input  logic                  clear_valid_i,
  input  logic [LVL_IN_W-1:0]   clear_level_i,
  input  logic [IDX_IN_W-1:0]   clear_index_i,
  input  logic                  clear_all_i,
  input  logic [LVL_IN_W-1:0]   query_level_i,
  output logic                  query_hit_o,
  output logic                  any_pending_o,
  input  logic [NUM_LEVELS-1:0] sw_req_i,
  input  logic [LVL_IN_W-1:0]   cur_ipl_i,
  output logic                  irq_o,
  output logic [NUM_LEVELS-1:0] irq_summary_o,
  output logic [LVL_IN_W-1:0]   irq_id_o,
  output logic                  cmd_err_o
);
  logic [1:0]                       rst_sync_q;
  logic                             rst_n_int;
  logic [NUM_LEVELS-1:0]            post_lvl, clr_lvl;
  logic [SRC_W-1:0]                 post_bit, clr_bit;
  logic                             post_bad, clr_bad;
  logic [NUM_LEVELS-1:0][SRC_W-1:0] pend_vec;
  logic [NUM_LEVELS-1:0]            pend_sum;
  logic                             err_q, err_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  int_cmd_decode #(.NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W)) i_post_dec (
    .valid_i(post_valid_i), .level_i(post_level_i), .index_i(post_index_i),
    .lvl_sel_o(post_lvl), .bit_sel_o(post_bit), .bad_o(post_bad));

  int_cmd_decode #(.NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W)) i_clr_dec (
    .valid_i(clear_valid_i), .level_i(clear_level_i), .index_i(clear_index_i),
    .lvl_sel_o(clr_lvl), .bit_sel_o(clr_bit), .bad_o(clr_bad));

  int_pend_store #(.NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W)) i_store (
    .clk_i(clk_i), .rst_ni(rst_n_int), .clear_all_i(clear_all_i),
    .post_lvl_i(post_lvl), .post_bit_i(post_bit),
    .clr_lvl_i(clr_lvl), .clr_bit_i(clr_bit),
    .vec_o(pend_vec), .sum_o(pend_sum));

  int_prio_eval #(.NUM_LEVELS(NUM_LEVELS), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
                  .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)) i_eval (
    .sw_req_i(sw_req_i), .sum_i(pend_sum), .cur_ipl_i(cur_ipl_i),
    .irq_o(irq_o), .mask_o(irq_summary_o), .id_o(irq_id_o));

  always_comb begin
    err_d = post_bad || clr_bad;
    if (32'(query_level_i) < NUM_LEVELS)
      query_hit_o = |pend_vec[query_level_i[LVL_W-1:0]];
    else
      query_hit_o = 1'b0;
    any_pending_o = |pend_sum;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) err_q <= 1'b0;
    else            err_q <= err_d;
  end
  assign cmd_err_o = err_q;
endmodule

// File: rtl/int_prio_ctrl_chk.sv
module int_prio_ctrl_chk #(
  parameter int unsigned NUM_LEVELS = 32,
  parameter int unsigned SRC_W      = 64,
  parameter int unsigned EXT_MIN    = 16,
  parameter int unsigned EXT_MAX    = 32,
  localparam int unsigned LVL_W     = $clog2(NUM_LEVELS),
  localparam int unsigned LVL_IN_W  = LVL_W + 1,
  localparam int unsigned IDX_IN_W  = $clog2(SRC_W) + 1
) (
  input logic                  clk_i,
  input logic                  rst_n_int,
  input logic                  post_valid_i,
  input logic [LVL_IN_W-1:0]   post_level_i,
  input logic [IDX_IN_W-1:0]   post_index_i,
  input logic                  clear_valid_i,
  input logic [LVL_IN_W-1:0]   clear_level_i,
  input logic [IDX_IN_W-1:0]   clear_index_i,
  input logic                  clear_all_i,
  input logic                  query_hit_o,
  input logic                  any_pending_o,
  input logic [LVL_IN_W-1:0]   cur_ipl_i,
  input logic                  irq_o,
  input logic [NUM_LEVELS-1:0] irq_summary_o,
  input logic [LVL_IN_W-1:0]   irq_id_o,
  input logic                  cmd_err_o,
  input logic [NUM_LEVELS-1:0] pend_sum
);
  logic post_ok, any_bad, same_bit;
  assign post_ok  = post_valid_i && (32'(post_level_i) < NUM_LEVELS) && (32'(post_index_i) < SRC_W);
  assign any_bad  = (post_valid_i && ((32'(post_level_i) >= NUM_LEVELS) || (32'(post_index_i) >= SRC_W))) ||
                    (clear_valid_i && ((32'(clear_level_i) >= NUM_LEVELS) || (32'(clear_index_i) >= SRC_W)));
  assign same_bit = clear_valid_i && (clear_level_i == post_level_i) && (clear_index_i == post_index_i);

  p_post_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (post_ok && !clear_all_i && !same_bit) |=> pend_sum[$past(post_level_i[LVL_W-1:0])]);

  p_empty_no_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !any_pending_o |-> !query_hit_o);

  p_clear_all_r4: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    clear_all_i |=> !any_pending_o);

  p_ext_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (irq_o && (pend_sum[EXT_MAX-1:EXT_MIN] != '0)) |-> (32'(irq_id_o) >= EXT_MIN));

  p_strict_r9: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    irq_o |-> (irq_id_o > cur_ipl_i));

  p_idle_outs_r9: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !irq_o |-> ((irq_id_o == '0) && (irq_summary_o == '0)));

  p_err_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    any_bad |=> cmd_err_o);

  p_err_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !any_bad |=> !cmd_err_o);
endmodule

bind int_prio_ctrl int_prio_ctrl_chk #(
  .NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W), .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)
) i_chk (
  .clk_i(clk_i), .rst_n_int(rst_n_int),
  .post_valid_i(post_valid_i), .post_level_i(post_level_i), .post_index_i(post_index_i),
  .clear_valid_i(clear_valid_i), .clear_level_i(clear_level_i), .clear_index_i(clear_index_i),
  .clear_all_i(clear_all_i), .query_hit_o(query_hit_o), .any_pending_o(any_pending_o),
  .cur_ipl_i(cur_ipl_i), .irq_o(irq_o), .irq_summary_o(irq_summary_o), .irq_id_o(irq_id_o),
  .cmd_err_o(cmd_err_o), .pend_sum(pend_sum)
);

// File: tb/test_int_prio_ctrl.sv
module test_int_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        post_valid, clear_valid, clear_all;
  logic [5:0]  post_level, clear_level, query_level, cur_ipl;
  logic [6:0]  post_index, clear_index;
  logic [31:0] sw_req;
  logic        query_hit, any_pending, irq, cmd_err;
  logic [31:0] irq_summary;
  logic [5:0]  irq_id;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;

  always #2.5 clk = ~clk;

  int_prio_ctrl i_int_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .post_valid_i(post_valid), .post_level_i(post_level), .post_index_i(post_index),
    .clear_valid_i(clear_valid), .clear_level_i(clear_level), .clear_index_i(clear_index),
    .clear_all_i(clear_all), .query_level_i(query_level),
    .query_hit_o(query_hit), .any_pending_o(any_pending),
    .sw_req_i(sw_req), .cur_ipl_i(cur_ipl),
    .irq_o(irq), .irq_summary_o(irq_summary), .irq_id_o(irq_id), .cmd_err_o(cmd_err));

  typedef struct packed {
    logic [31:0] sw;
    logic [5:0]  lvl;   // 63 = nothing posted
    logic [5:0]  ipl;
    logic        irq;
    logic [5:0]  id;
    logic [31:0] sum;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{sw:32'h0000_0002, lvl:6'd63, ipl:6'd0,  irq:1'b1, id:6'd1,  sum:32'h0000_0002}, // R7 single
    '{sw:32'h0000_8002, lvl:6'd63, ipl:6'd0,  irq:1'b1, id:6'd15, sum:32'h0000_8002}, // R7 highest
    '{sw:32'h0000_8000, lvl:6'd63, ipl:6'd15, irq:1'b0, id:6'd0,  sum:32'h0000_0000}, // R9 equal
    '{sw:32'h0000_8000, lvl:6'd63, ipl:6'd14, irq:1'b1, id:6'd15, sum:32'h0000_8000}, // R9 below
    '{sw:32'h0000_0000, lvl:6'd20, ipl:6'd0,  irq:1'b1, id:6'd20, sum:32'h0010_0000}, // R8
    '{sw:32'h0000_8000, lvl:6'd20, ipl:6'd19, irq:1'b1, id:6'd20, sum:32'h0010_8000}, // R8 merge
    '{sw:32'h0000_8000, lvl:6'd20, ipl:6'd20, irq:1'b0, id:6'd0,  sum:32'h0000_0000}, // R9 equal
    '{sw:32'h0001_0001, lvl:6'd63, ipl:6'd0,  irq:1'b0, id:6'd0,  sum:32'h0000_0000}, // R7 ignored bits
    '{sw:32'h0000_0000, lvl:6'd5,  ipl:6'd0,  irq:1'b0, id:6'd0,  sum:32'h0000_0000}, // R8 low level
    '{sw:32'h0000_0000, lvl:6'd31, ipl:6'd30, irq:1'b1, id:6'd31, sum:32'h8000_0000}, // R8 top
    '{sw:32'h0000_0004, lvl:6'd16, ipl:6'd2,  irq:1'b1, id:6'd16, sum:32'h0001_0004}, // R8 bottom
    '{sw:32'h0000_0000, lvl:6'd63, ipl:6'd0,  irq:1'b0, id:6'd0,  sum:32'h0000_0000}  // R9 none
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic post(logic [5:0] l, logic [6:0] i);
    post_valid = 1'b1; post_level = l; post_index = i;
    cyc();
    post_valid = 1'b0;
  endtask

  task automatic clr(logic [5:0] l, logic [6:0] i);
    clear_valid = 1'b1; clear_level = l; clear_index = i;
    cyc();
    clear_valid = 1'b0;
  endtask

  task automatic wipe();
    clear_all = 1'b1;
    cyc();
    clear_all = 1'b0;
  endtask

  task automatic q(logic [5:0] l);
    query_level = l;
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    post_valid = 0; clear_valid = 0; clear_all = 0;
    post_level = 0; post_index = 0; clear_level = 0; clear_index = 0;
    query_level = 0; sw_req = 0; cur_ipl = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R1 reset state
    q(6'd0);
    chk("R1 query", query_hit, 0);
    chk("R1 any", any_pending, 0);
    chk("R1 irq", irq, 0);
    chk("R1 err", cmd_err, 0);

    // evaluation table (R7, R8, R9)
    for (int k = 0; k < NVEC; k++) begin
      wipe();
      if (VECS[k].lvl != 6'd63) post(VECS[k].lvl, 7'd3);
      sw_req = VECS[k].sw; cur_ipl = VECS[k].ipl;
      #1;
      chk("R9 irq", irq, VECS[k].irq);
      chk("R7/R8 id", irq_id, VECS[k].id);
      chk("R7/R8 summary", irq_summary, VECS[k].sum);
    end
    sw_req = 0; cur_ipl = 0;
    wipe();

    // R2 post
    post(6'd3, 7'd10);
    q(6'd3); chk("R2 hit", query_hit, 1);
    chk("R2 any", any_pending, 1);
    q(6'd4); chk("R2 other level", query_hit, 0);

    // R3 clear with two sources
    post(6'd3, 7'd20);
    clr(6'd3, 7'd10);
    q(6'd3); chk("R3 still pending", query_hit, 1);
    clr(6'd3, 7'd20);
    q(6'd3); chk("R3 emptied", query_hit, 0);
    chk("R3 any", any_pending, 0);

    // R5 collision
    post_valid = 1; post_level = 6'd7; post_index = 7'd5;
    clear_valid = 1; clear_level = 6'd7; clear_index = 7'd5;
    cyc();
    post_valid = 0; clear_valid = 0;
    q(6'd7); chk("R5 clear wins", query_hit, 0);

    // R4 clear-all overrides simultaneous post
    post(6'd8, 7'd1);
    clear_all = 1; post_valid = 1; post_level = 6'd9; post_index = 7'd2;
    cyc();
    clear_all = 0; post_valid = 0;
    q(6'd8); chk("R4 level 8", query_hit, 0);
    q(6'd9); chk("R4 level 9", query_hit, 0);
    chk("R4 any", any_pending, 0);

    // R6 out-of-range query aliasing onto level 8
    post(6'd8, 7'd0);
    q(6'd40); chk("R6 out-of-range query", query_hit, 0);
    q(6'd8);  chk("R6 in-range query", query_hit, 1);
    wipe();

    // R10 bad level would alias to level 0
    post(6'd32, 7'd0);
    chk("R10 err pulse", cmd_err, 1);
    q(6'd0); chk("R10 level ignored", query_hit, 0);
    chk("R10 any", any_pending, 0);
    cyc();
    chk("R10 err one cycle", cmd_err, 0);
    // bad index would alias to source 0 of level 1
    post(6'd1, 7'd64);
    chk("R10 err index", cmd_err, 1);
    q(6'd1); chk("R10 index ignored", query_hit, 0);
    // bad clear would alias to level 2
    post(6'd2, 7'd0);
    clr(6'd34, 7'd0);
    chk("R10 err clear", cmd_err, 1);
    q(6'd2); chk("R10 clear ignored", query_hit, 1);

    done = 1'b1;
    finish_run();
  end
endmodule